// File: doc/BRIEF.md
# Multicast Packet Copy Engine

This block sits between the lookup stage and the queue manager of a packet router. It accepts one forwarding decision per packet and turns it into enqueue requests. A unicast decision that carries a resolved next-hop MAC address produces a single enqueue. A multicast decision carries a copy vector with one bit per destination: outputs 0 to 4 and plugins 5 to 9. It produces one enqueue for each set bit. All the copies share one buffer.

Before any copy is issued, the block writes two things to the packet's buffer descriptor through a one-cycle write port. The first is a reference count, set to the number of copies. The second is the destination MAC address. For unicast that address is the next-hop MAC. For multicast it is derived from the IP destination and shared by all copies. Enqueue records then leave through a valid/ready interface, one per cycle while the consumer is ready.

Top module: `mce_copy_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and both `eq_valid` and `dw_valid` are 0; a reset during a packet abandons the packet.
- R2: A multicast decision yields one enqueue per set bit of `in_copy_vec`, in ascending bit order. `eq_port` equals the bit index: indices 0-4 are outputs and 5-9 are plugins.
- R3: For multicast, `dw_mac` is 0x01005E in bits 47:24, 0 in bit 23, and `in_ip_dst[22:0]` in bits 22:0.
- R4: `dw_refcnt` (4 bits) equals the number of enqueues the packet will produce (1 for unicast).
- R5: `dw_valid` pulses for exactly one cycle per packet, in the cycle after the decision is accepted. The first enqueue appears in the following cycle.
- R6: Copies to outputs (index below 5) carry `in_qid`; copies to plugins carry a queue ID of zero.
- R7: Every enqueue of a packet carries that packet's `in_handle`, `in_stats` and `in_len` unchanged.
- R8: A unicast decision with `in_mac_ok`=1 and `in_port` below 10 yields one enqueue to `in_port`, with `dw_mac` equal to `in_nh_mac`.
- R9: A decision is dropped, with no descriptor write, no enqueue and `in_ready` remaining 1, in three cases: multicast with an all-zero vector, unicast with `in_mac_ok`=0, or unicast with `in_port` of 10 or more.
- R10: While `eq_valid` is 1 and `eq_ready` is 0, the enqueue record holds steady. With `eq_ready` held at 1, a new copy appears every cycle.
- R11: `in_ready` is 0 from the accepting edge until the edge at which the last copy is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decision present |
| in_ready | output | 1 | Engine idle, decision accepted on this edge |
| in_mcast | input | 1 | 1 = multicast decision |
| in_mac_ok | input | 1 | Unicast next-hop MAC is valid |
| in_copy_vec | input | 10 | Multicast destination bit vector |
| in_port | input | 4 | Unicast destination index |
| in_handle | input | HANDLE_W (24) | Buffer handle |
| in_qid | input | QID_W (17) | Queue ID |
| in_stats | input | 16 | Stats index |
| in_len | input | 16 | Frame length |
| in_nh_mac | input | 48 | Unicast next-hop MAC |
| in_ip_dst | input | 32 | IP destination address |
| dw_valid | output | 1 | Descriptor write strobe |
| dw_handle | output | HANDLE_W (24) | Descriptor to write |
| dw_refcnt | output | 4 | Reference count value |
| dw_mac | output | 48 | Destination MAC value |
| eq_valid | output | 1 | Enqueue record valid |
| eq_ready | input | 1 | Queue manager takes record |
| eq_handle | output | HANDLE_W (24) | Buffer handle |
| eq_qid | output | QID_W (17) | Queue ID |
| eq_stats | output | 16 | Stats index |
| eq_len | output | 16 | Frame length |
| eq_port | output | 4 | Destination index |

## Verification
The assertions assume that the queue manager may hold `eq_ready` low for any time. They also assume that decisions arrive only as single-cycle `in_valid` pulses while `in_ready` is high, so no decision is offered mid-packet. The stimulus follows both rules. It presents each decision for one cycle and then waits for the engine to return idle. It varies `eq_ready` only in the directed backpressure case.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int REF_W  = 4;
  localparam int MAC_W  = 48;
  localparam int IP_W   = 32;
  localparam int STAT_W = 16;
  localparam int LEN_W  = 16;

  typedef enum logic {ST_IDLE, ST_ISSUE} mce_state_e;

  function automatic logic [REF_W-1:0] count_bits(input logic [31:0] v);
    logic [REF_W-1:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + REF_W'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/mce_mac_form.sv
module mce_mac_form
  import mce_pkg::*;
#(
  parameter logic [23:0] GROUP_OUI = 24'h01005E
) (
  input  logic             mcast,
  input  logic [IP_W-1:0]  ip_dst,
  input  logic [MAC_W-1:0] nh_mac,
  output logic [MAC_W-1:0] mac
);
  // Group MAC keeps 23 low address bits; bit 23 of the MAC is forced low.
  always_comb begin
    if (mcast) mac = {GROUP_OUI, 1'b0, ip_dst[22:0]};
    else       mac = nh_mac;
  end
endmodule

// File: rtl/mce_low_pick.sv
module mce_low_pick #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_sel
      if (g == 0) begin : g_first
        assign onehot[g] = vec[0];
      end else begin : g_rest
        assign onehot[g] = vec[g] & ~(|vec[g-1:0]);
      end
    end
  endgenerate

  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (onehot[i]) idx = idx | IW'(i);
  end
endmodule

// File: rtl/mce_copy_engine.sv
module mce_copy_engine
  import mce_pkg::*;
#(
  parameter int HANDLE_W = 24,
  parameter int QID_W    = 17,
  parameter int NUM_OUT  = 5,
  parameter int NUM_PLUG = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_mcast,
  input  logic                   in_mac_ok,
  input  logic [NUM_OUT+NUM_PLUG-1:0] in_copy_vec,
  input  logic [$clog2(NUM_OUT+NUM_PLUG)-1:0] in_port,
  input  logic [HANDLE_W-1:0]    in_handle,
  input  logic [QID_W-1:0]       in_qid,
  input  logic [STAT_W-1:0]      in_stats,
  input  logic [LEN_W-1:0]       in_len,
  input  logic [MAC_W-1:0]       in_nh_mac,
  input  logic [IP_W-1:0]        in_ip_dst,
  output logic                   dw_valid,
  output logic [HANDLE_W-1:0]    dw_handle,
  output logic [REF_W-1:0]       dw_refcnt,
  output logic [MAC_W-1:0]       dw_mac,
  output logic                   eq_valid,
  input  logic                   eq_ready,
  output logic [HANDLE_W-1:0]    eq_handle,
  output logic [QID_W-1:0]       eq_qid,
  output logic [STAT_W-1:0]      eq_stats,
  output logic [LEN_W-1:0]       eq_len,
  output logic [$clog2(NUM_OUT+NUM_PLUG)-1:0] eq_port
);
  localparam int DEST   = NUM_OUT + NUM_PLUG;
  localparam int PORT_W = $clog2(DEST);

  mce_state_e          state;
  logic [DEST-1:0]     rem;
  logic [DEST-1:0]     vec_eff;
  logic [MAC_W-1:0]    mac_now;
  logic [HANDLE_W-1:0] hold_handle;
  logic [QID_W-1:0]    hold_qid;
  logic [STAT_W-1:0]   hold_stats;
  logic [LEN_W-1:0]    hold_len;
  logic                pick_any;
  logic [DEST-1:0]     pick_sel;
  logic [PORT_W-1:0]   pick_idx;

  // Unicast folds into the same vector as a single-bit destination set.
  always_comb begin
    if (in_mcast)
      vec_eff = in_copy_vec;
    else if (in_mac_ok && (32'(in_port) < DEST))
      vec_eff = {{(DEST-1){1'b0}}, 1'b1} << in_port;
    else
      vec_eff = '0;
  end

  mce_mac_form u_mac (
    .mcast  (in_mcast),
    .ip_dst (in_ip_dst),
    .nh_mac (in_nh_mac),
    .mac    (mac_now)
  );

  mce_low_pick #(.N(DEST), .IW(PORT_W)) u_pick (
    .vec    (rem),
    .any    (pick_any),
    .onehot (pick_sel),
    .idx    (pick_idx)
  );

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rem         <= '0;
      dw_valid    <= 1'b0;
      dw_handle   <= '0;
      dw_refcnt   <= '0;
      dw_mac      <= '0;
      eq_valid    <= 1'b0;
      eq_handle   <= '0;
      eq_qid      <= '0;
      eq_stats    <= '0;
      eq_len      <= '0;
      eq_port     <= '0;
      hold_handle <= '0;
      hold_qid    <= '0;
      hold_stats  <= '0;
      hold_len    <= '0;
    end else begin
      dw_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && (vec_eff != '0)) begin
            state       <= ST_ISSUE;
            rem         <= vec_eff;
            dw_valid    <= 1'b1;
            dw_handle   <= in_handle;
            dw_refcnt   <= count_bits(32'(vec_eff));
            dw_mac      <= mac_now;
            hold_handle <= in_handle;
            hold_qid    <= in_qid;
            hold_stats  <= in_stats;
            hold_len    <= in_len;
          end
        end
        default: begin
          if (!eq_valid || eq_ready) begin
            if (pick_any) begin
              eq_valid  <= 1'b1;
              eq_port   <= pick_idx;
              eq_qid    <= (32'(pick_idx) >= NUM_OUT) ? '0 : hold_qid;
              eq_handle <= hold_handle;
              eq_stats  <= hold_stats;
              eq_len    <= hold_len;
              rem       <= rem & ~pick_sel;
            end else begin
              eq_valid <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R5: descriptor write is followed by the first copy
  p_desc_then_copy_r5: assert property (@(posedge clk) disable iff (rst)
    dw_valid |=> eq_valid);
  // R5: a packet's first copy is always preceded by its descriptor write
  p_copy_after_desc_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(eq_valid) |-> $past(dw_valid));
  // R4: reference count lies within the destination count
  p_refcnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    dw_valid |-> (dw_refcnt != '0) && (32'(dw_refcnt) <= DEST));
  // R6: plugin copies carry a zero queue ID
  p_plugin_qid_r6: assert property (@(posedge clk) disable iff (rst)
    (eq_valid && (32'(eq_port) >= NUM_OUT)) |-> (eq_qid == '0));
  // R10: a stalled record holds steady
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (eq_valid && !eq_ready) |=> (eq_valid && $stable(eq_port)
      && $stable(eq_handle) && $stable(eq_qid)));
  // R11: no acceptance while copies are outstanding
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    eq_valid |-> !in_ready);
  // R2: successive copies go to strictly rising indices
  p_ascend_r2: assert property (@(posedge clk) disable iff (rst)
    (eq_valid && eq_ready) |=> (!eq_valid || (eq_port > $past(eq_port))));
endmodule

// File: tb/mce_copy_engine_bench.sv
module mce_copy_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mcast;
    logic        mac_ok;
    logic [9:0]  vec;
    logic [3:0]  port;
    logic [31:0] ip;
    logic [47:0] nh;
    logic [16:0] qid;
    logic [23:0] handle;
  } pkt_t;

  localparam int NTAB = 6;
  localparam pkt_t TAB [NTAB] = '{
    '{1'b1, 1'b0, 10'b1000000001, 4'd0, 32'hE0FFAB12, 48'h0, 17'h1ABCD, 24'h000101},
    '{1'b1, 1'b0, 10'b1111111111, 4'd0, 32'hEF80_0001, 48'h0, 17'h00042, 24'h000202},
    '{1'b1, 1'b0, 10'b0000010000, 4'd0, 32'hE1234567, 48'h0, 17'h0FFFF, 24'h000303},
    '{1'b1, 1'b0, 10'b0000100000, 4'd0, 32'hE07FFFFF, 48'h0, 17'h00007, 24'h000404},
    '{1'b0, 1'b1, 10'b0000000000, 4'd3, 32'h0A000001, 48'h0011_2233_4455, 17'h00099, 24'h000505},
    '{1'b0, 1'b1, 10'b1111111111, 4'd7, 32'h0A000002, 48'hA0B0_C0D0_E0F0, 17'h12345, 24'h000606}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_mcast = 1'b0, in_mac_ok = 1'b0, eq_ready = 1'b1;
  logic [9:0]  in_copy_vec = '0;
  logic [3:0]  in_port = '0;
  logic [23:0] in_handle = '0;
  logic [16:0] in_qid = '0;
  logic [15:0] in_stats = '0, in_len = '0;
  logic [47:0] in_nh_mac = '0;
  logic [31:0] in_ip_dst = '0;
  logic in_ready, dw_valid, eq_valid;
  logic [23:0] dw_handle, eq_handle;
  logic [3:0]  dw_refcnt, eq_port;
  logic [47:0] dw_mac;
  logic [16:0] eq_qid;
  logic [15:0] eq_stats, eq_len;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mce_copy_engine u_mce_copy_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcast(in_mcast), .in_mac_ok(in_mac_ok), .in_copy_vec(in_copy_vec),
    .in_port(in_port), .in_handle(in_handle), .in_qid(in_qid),
    .in_stats(in_stats), .in_len(in_len), .in_nh_mac(in_nh_mac),
    .in_ip_dst(in_ip_dst), .dw_valid(dw_valid), .dw_handle(dw_handle),
    .dw_refcnt(dw_refcnt), .dw_mac(dw_mac), .eq_valid(eq_valid),
    .eq_ready(eq_ready), .eq_handle(eq_handle), .eq_qid(eq_qid),
    .eq_stats(eq_stats), .eq_len(eq_len), .eq_port(eq_port)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input pkt_t p, input logic [15:0] st, input logic [15:0] ln);
    @(negedge clk);
    chk("R11 idle before offer", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_mcast = p.mcast; in_mac_ok = p.mac_ok;
    in_copy_vec = p.vec; in_port = p.port; in_ip_dst = p.ip;
    in_nh_mac = p.nh; in_qid = p.qid; in_handle = p.handle;
    in_stats = st; in_len = ln;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_pkt(input pkt_t p, input logic [15:0] st, input logic [15:0] ln);
    logic [9:0] ev;
    int cnt;
    ev = '0;
    if (p.mcast) ev = p.vec;
    else if (p.mac_ok && p.port < 4'd10) ev = 10'(1) << p.port;
    cnt = 0;
    for (int i = 0; i < 10; i++) cnt += int'(ev[i]);
    drive(p, st, ln);
    if (ev == '0) begin
      for (int k = 0; k < 3; k++) begin
        chk("R9 no descriptor write", 64'(dw_valid), 64'd0);
        chk("R9 no enqueue", 64'(eq_valid), 64'd0);
        chk("R9 stays ready", 64'(in_ready), 64'd1);
        @(negedge clk);
      end
      return;
    end
    chk("R5 descriptor pulse", 64'(dw_valid), 64'd1);
    chk("R5 no copy with write", 64'(eq_valid), 64'd0);
    chk("R4 refcount", 64'(dw_refcnt), 64'(cnt));
    chk("R7 descriptor handle", 64'(dw_handle), 64'(p.handle));
    if (p.mcast) chk("R3 group MAC", 64'(dw_mac), 64'({24'h01005E, 1'b0, p.ip[22:0]}));
    else         chk("R8 next-hop MAC", 64'(dw_mac), 64'(p.nh));
    chk("R11 busy after accept", 64'(in_ready), 64'd0);
    for (int i = 0; i < 10; i++) begin
      if (ev[i]) begin
        @(negedge clk);
        chk("R10 copy each cycle", 64'(eq_valid), 64'd1);
        chk("R2 copy port order", 64'(eq_port), 64'(i));
        chk("R6 queue id", 64'(eq_qid), (i >= 5) ? 64'd0 : 64'(p.qid));
        chk("R7 handle", 64'(eq_handle), 64'(p.handle));
        chk("R7 stats", 64'(eq_stats), 64'(st));
        chk("R7 length", 64'(eq_len), 64'(ln));
        chk("R5 single write", 64'(dw_valid), 64'd0);
      end
    end
    @(negedge clk);
    chk("R11 ready after last", 64'(in_ready), 64'd1);
    chk("R2 copy count ends", 64'(eq_valid), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pkt_t p;
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", 64'(in_ready), 64'd1);
    chk("R1 reset eq_valid", 64'(eq_valid), 64'd0);
    chk("R1 reset dw_valid", 64'(dw_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int t = 0; t < NTAB; t++)
      run_pkt(TAB[t], 16'(16'h100 + t), 16'(64 + 8 * t));

    // R9: drop cases
    p = '{1'b1, 1'b0, 10'b0, 4'd0, 32'hE0000001, 48'h0, 17'h1, 24'h777};
    run_pkt(p, 16'h1, 16'd60);
    p = '{1'b0, 1'b0, 10'b0, 4'd2, 32'h0A000003, 48'h123456789ABC, 17'h2, 24'h778};
    run_pkt(p, 16'h2, 16'd61);
    p = '{1'b0, 1'b1, 10'b0, 4'd12, 32'h0A000004, 48'h123456789ABC, 17'h3, 24'h779};
    run_pkt(p, 16'h3, 16'd62);

    // R10: backpressure holds the record
    eq_ready = 1'b0;
    p = '{1'b1, 1'b0, 10'b0000000111, 4'd0, 32'hE0000005, 48'h0, 17'h55, 24'h888};
    drive(p, 16'h9, 16'd90);
    chk("R5 write under stall", 64'(dw_valid), 64'd1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", 64'(eq_valid), 64'd1);
      chk("R10 held port", 64'(eq_port), 64'd0);
      @(negedge clk);
    end
    eq_ready = 1'b1;
    @(negedge clk);
    chk("R10 second copy", 64'(eq_port), 64'd1);
    @(negedge clk);
    chk("R10 third copy", 64'(eq_port), 64'd2);
    @(negedge clk);
    chk("R11 idle after stall", 64'(in_ready), 64'd1);

    // R1: reset in the middle of a packet
    p = '{1'b1, 1'b0, 10'b1111100000, 4'd0, 32'hE0000006, 48'h0, 17'h66, 24'h999};
    drive(p, 16'h7, 16'd70);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset eq_valid", 64'(eq_valid), 64'd0);
    chk("R1 mid reset in_ready", 64'(in_ready), 64'd1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 no stray copy", 64'(eq_valid), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule